// File: doc/BRIEF.md
# Direct-Mapped Next-PC Predictor

This block tells an instruction fetch stage where to fetch next. Each cycle, fetch presents the PC it is about to fetch. The block returns, through combinational logic, a predicted next PC. The prediction is taken from a small table that remembers where particular branch instructions last went. When the table has no valid entry for the PC, the block returns the sequential address, PC plus 4. A lookup is a pure read and never changes the table.

The execute stage resolves branches later in the pipeline. When a resolved next PC disagrees with what was predicted, execute sends the branch's own address together with the correct next PC. The table is direct-mapped and has 16 slots. The slot is chosen by PC bits [5:2]. PC bits [31:6] are stored as a tag, alongside the remembered target and a valid flag. An update always replaces whatever the chosen slot held before.

Top module: `next_pc_btb`

## Requirements
- R1: While reset is asserted and after it is released, every slot is invalid, so every lookup returns lookup PC + 4 until the first update.
- R2: A lookup with no valid matching slot returns lookup PC + 4, computed modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R3: A lookup whose slot is valid and whose tag matches returns the target stored by the most recent update to that slot.
- R4: The slot index is PC bits [5:2] and the tag is PC bits [31:6]. PC bits [1:0] take part in neither the index nor the tag, so lookups that differ only in those bits get the same prediction.
- R5: A lookup that selects a valid slot holding a different tag is a miss and returns lookup PC + 4.
- R6: An update written on a clock edge is seen by lookups from the next cycle on. A lookup in the same cycle as an update sees the table as it was before that update.
- R7: An update to a slot that already holds a different tag replaces the entry. The displaced branch address then misses, and the new one hits.
- R8: Lookups have no side effect: with no update, the same lookup PC keeps giving the same prediction cycle after cycle.
- R9: While the update-valid input is low, the update address and target inputs do not change the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low; invalidates every slot |
| lookupPc | input | 32 | PC being fetched this cycle |
| predNextPc | output | 32 | Predicted next PC for lookupPc (combinational) |
| updValid | input | 1 | Writes updPc/updTarget into the table on this clock edge |
| updPc | input | 32 | Address of the mispredicted branch |
| updTarget | input | 32 | Correct next PC that branch resolved to |

## Verification
Each slot is either valid or not, and holds a tag and a target. A wrong value in any of these shows up on predNextPc in the same cycle that a lookup selects that slot. A stale valid bit or a wrong tag turns an expected PC + 4 into a stored target, or the reverse. A target that was not overwritten returns the old address. A write that lands on the wrong edge or in the wrong slot becomes visible one cycle after the update, when the affected PC is looked up. The bench therefore compares the prediction on every clock. It holds the lookup on updated and aliasing addresses right after each write, so any such fault is reported at most one cycle after it arises.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Default geometry: 32-bit PCs, word-aligned, 16 slots
  localparam int unsigned PC_W  = 32;
  localparam int unsigned OFS_W = 2;
  localparam int unsigned IDX_W = 4;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrEn;    // a table write happens on this edge
    logic flush;   // invalidate every slot on this edge
  } btbStrobe_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = btb_pkg::IDX_W,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic               rstN,
  input  logic               updValid,
  input  logic [IDX_W-1:0]   updIdx,
  output btbStrobe_t         strobe,
  output logic [ENTRIES-1:0] wrSel
);
  always_comb begin
    strobe.flush = !rstN;
    strobe.wrEn  = rstN && updValid;
  end

  // One-hot slot select for the write port
  for (genvar i = 0; i < ENTRIES; i++) begin : g_dec
    assign wrSel[i] = (updIdx == IDX_W'(i));
  end
endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = btb_pkg::PC_W,
  parameter int unsigned OFS_W = btb_pkg::OFS_W,
  parameter int unsigned IDX_W = btb_pkg::IDX_W,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned TAG_W   = PC_W - IDX_W - OFS_W
) (
  input  logic               clk,
  input  btbStrobe_t         strobe,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic [TAG_W-1:0]   updTag,
  input  logic [PC_W-1:0]    updTarget,
  input  logic [PC_W-1:0]    lookupPc,
  output logic [PC_W-1:0]    predNextPc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFS_W;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [PC_W-1:0]    tgtQ [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.flush) begin
        validQ[i] <= 1'b0;
        tagQ[i]   <= '0;
        tgtQ[i]   <= '0;
      end else if (strobe.wrEn && wrSel[i]) begin
        validQ[i] <= 1'b1;
        tagQ[i]   <= updTag;
        tgtQ[i]   <= updTarget;
      end
    end
  end

  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag;
  logic             lkHit;
  logic [PC_W-1:0]  seqPc;

  always_comb begin
    lkIdx      = lookupPc[OFS_W +: IDX_W];
    lkTag      = lookupPc[PC_W-1 -: TAG_W];
    seqPc      = lookupPc + STEP;
    lkHit      = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
    predNextPc = lkHit ? tgtQ[lkIdx] : seqPc;
  end
endmodule

// File: rtl/next_pc_btb.sv
module next_pc_btb
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = btb_pkg::PC_W,
  parameter int unsigned OFS_W = btb_pkg::OFS_W,
  parameter int unsigned IDX_W = btb_pkg::IDX_W,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned TAG_W   = PC_W - IDX_W - OFS_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic [PC_W-1:0] predNextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget
);
  btbStrobe_t         strobe;
  logic [ENTRIES-1:0] wrSel;

  // Byte-offset bits of a word-aligned branch address carry no information
  logic unusedOfsBits;
  assign unusedOfsBits = ^updPc[OFS_W-1:0];

  btb_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .rstN    (rstN),
    .updValid(updValid),
    .updIdx  (updPc[OFS_W +: IDX_W]),
    .strobe  (strobe),
    .wrSel   (wrSel)
  );

  btb_datapath #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) dp_i (
    .clk       (clk),
    .strobe    (strobe),
    .wrSel     (wrSel),
    .updTag    (updPc[PC_W-1 -: TAG_W]),
    .updTarget (updTarget),
    .lookupPc  (lookupPc),
    .predNextPc(predNextPc)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int unsigned PC_W  = btb_pkg::PC_W,
  parameter int unsigned OFS_W = btb_pkg::OFS_W,
  parameter int unsigned IDX_W = btb_pkg::IDX_W,
  localparam int unsigned HI_LO = OFS_W + IDX_W
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic [PC_W-1:0] predNextPc,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic [PC_W-1:0] updTarget
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFS_W;

  // R1: first cycle out of reset, nothing is stored
  assert_reset_seq_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (predNextPc == lookupPc + STEP));

  // R6/R3: a write is visible on the very next cycle for the same word address
  assert_update_visible_R6: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (!(lookupPc[PC_W-1:OFS_W] == $past(updPc[PC_W-1:OFS_W]))
                  || (predNextPc == $past(updTarget))));

  // R5/R7: right after a write, a different tag in that slot misses
  assert_alias_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (!((lookupPc[OFS_W +: IDX_W] == $past(updPc[OFS_W +: IDX_W]))
                    && (lookupPc[PC_W-1:HI_LO] != $past(updPc[PC_W-1:HI_LO])))
                  || (predNextPc == lookupPc + STEP)));

  // R8: no update and same lookup PC -> same prediction
  assert_lookup_pure_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updValid) && $stable(lookupPc)) |-> $stable(predNextPc));
endmodule

bind next_pc_btb btb_checker #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/next_pc_btb_tb.sv
module next_pc_btb_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic [31:0] predNextPc;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  next_pc_btb dut_i (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predNextPc(predNextPc),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget)
  );

  // Reference: map slot number -> (branch word address, target)
  logic [31:0] refAddr [int];
  logic [31:0] refTgt  [int];

  function automatic logic [31:0] refPredict(input logic [31:0] pc);
    int k = int'(pc[5:2]);
    if (refAddr.exists(k) && refAddr[k][31:6] == pc[31:6]) return refTgt[k];
    return pc + 32'd4;
  endfunction

  task automatic step(input logic [31:0] pc, input logic uv,
                      input logic [31:0] upc, input logic [31:0] utgt,
                      input string req);
    logic [31:0] exp;
    @(negedge clk);
    lookupPc = pc; updValid = uv; updPc = upc; updTarget = utgt;
    #2;
    exp = refPredict(pc);
    total++;
    if (predNextPc !== exp) begin
      bad++;
      $display("FAIL %s pc=%h actual=%h expected=%h", req, pc, predNextPc, exp);
    end
    @(posedge clk);
    if (!rstN) begin
      refAddr.delete(); refTgt.delete();
    end else if (uv) begin
      refAddr[int'(upc[5:2])] = upc;
      refTgt[int'(upc[5:2])]  = utgt;
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 1'b0, 32'h0, 32'h0, req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r = 32'h1234_5678;
    // R1: predictions during reset, even with update-valid high
    step(32'h0000_0100, 1'b1, 32'h0000_0100, 32'hDEAD_0000, "R1");
    step(32'h0000_0200, 1'b0, 32'h0, 32'h0, "R1");
    rstN = 1'b1;
    look(32'h0000_0100, "R1");
    look(32'h8000_0030, "R1 R2");
    // R2: wrap of sequential address
    look(32'hFFFF_FFFC, "R2");
    // R6: same-cycle predict sees old contents, next cycle sees new
    step(32'h0000_0100, 1'b1, 32'h0000_0100, 32'h0000_2000, "R6");
    look(32'h0000_0100, "R6 R3");
    // R4: low two bits ignored
    look(32'h0000_0102, "R4");
    look(32'h0000_0103, "R4");
    // R5: same slot, different tag
    look(32'h0000_0140, "R5");
    // R8: repeated lookups
    look(32'h0000_0100, "R8");
    look(32'h0000_0100, "R8");
    // R9: update inputs ignored when not valid
    step(32'h0000_0100, 1'b0, 32'h0000_0100, 32'h0000_9999, "R9");
    look(32'h0000_0100, "R9");
    // R7: overwrite with different tag
    step(32'h0000_0140, 1'b1, 32'h0000_0140, 32'h0000_3000, "R7");
    look(32'h0000_0140, "R7");
    look(32'h0000_0100, "R7");
    // R3: fill every slot, then read each back
    for (int i = 0; i < 16; i++)
      step(32'h0, 1'b1, 32'h0004_0000 | (i << 2), 32'hA000_0000 + i * 16, "R3");
    for (int i = 0; i < 16; i++)
      look(32'h0004_0000 | (i << 2), "R3");
    // R6: back-to-back updates to one slot, looked up each cycle
    step(32'h0004_0008, 1'b1, 32'h0004_0008, 32'h0000_5550, "R6");
    step(32'h0004_0008, 1'b1, 32'h0004_0008, 32'h0000_6660, "R6");
    look(32'h0004_0008, "R6");
    // Mixed traffic over few tags so hits, aliases and overwrites all occur
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a, b;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      a = {24'h000001, r[7:0]};
      b = {24'h000001, r[15:8]};
      step(a, r[16] & r[17], b, {8'h00, r[31:8]}, "R3 R5 R6 R7");
    end
    // R1: reset again clears learned entries
    rstN = 1'b0;
    step(32'h0004_0000, 1'b0, 32'h0, 32'h0, "R1");
    rstN = 1'b1;
    look(32'h0004_0000, "R1");
    look(32'h0004_0008, "R1");
    finish_run();
  end
endmodule